// File: doc/BRIEF.md
# Two-Digit Key History Display

This block remembers the two hex keys registered last and shows them on a two-digit common-anode seven-segment display. A keypad front end delivers a 4-bit code with a one-cycle strobe. On each strobe the history moves by one place. The previous newest key becomes the older digit, and the new code becomes the newest digit. Between strobes both stored digits hold.

Only one 4-to-7 decoder is built. Its input alternates between the two stored digits. A clock-enable divider sets how long each digit is shown, so every part of the block runs on one clock. Both digits get exactly the same number of cycles in each refresh period, which keeps their brightness equal. The divider parameter is chosen so that each digit refreshes at about 100 Hz or faster.

Top module: `key_hist_disp`

## Requirements
- R1: While reset is asserted and just after it is released, both stored digits are 0. Digit 0 (the newest key) is shown first, so `dig_en_no` = 2'b10 and `seg_no` shows the glyph for 0.
- R2: When `new_key_i` is high at a rising edge, the newest digit takes `key_i` at that edge and the older digit takes the previous newest value.
- R3: When `new_key_i` is low at a rising edge, neither stored digit changes.
- R4: Exactly one bit of `dig_en_no` is low at any time. Both enables are active low. Bit 0 enables the newest digit and bit 1 enables the older digit.
- R5: After reset, digit 0 is enabled for exactly `SLOT_CYCLES` clock cycles, then digit 1 for exactly `SLOT_CYCLES` cycles, and this alternation repeats without end.
- R6: `seg_no` is the active-low glyph of the enabled digit, with bits {g,f,e,d,c,b,a}. In hex the glyphs are: 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10, A=08, b=03, C=46, d=21, E=06, F=0E. All ones (7F) would blank the digit.
- R7: A strobe that falls in the same cycle as a digit switch still updates the history. The new value then appears on the digit that becomes enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_key_i | input | 1 | One-cycle strobe: a new key has been registered |
| key_i | input | 4 | Hex code of the registered key |
| seg_no | output | 7 | Active-low segment lines {g,f,e,d,c,b,a}, shared by both digits |
| dig_en_no | output | 2 | Active-low digit enables; bit 0 newest, bit 1 older |

## Verification
The assertions assume that `key_i` carries a valid code in any cycle where `new_key_i` is high. They place no limit on how strobes are spaced, so strobes on consecutive cycles are legal. The bench drives strobes at random density with random codes. It adds directed bursts of back-to-back strobes, a sweep through all sixteen codes, and a strobe placed on a slot boundary. A reset is also applied in the middle of the run. Because only one digit can be seen at a time, the stored history is checked through `seg_no` in every cycle, against a model of the history and the slot timing.

// File: rtl/key_disp_pkg.sv
package key_disp_pkg;
  typedef logic [3:0] nib_t;
  typedef logic [6:0] seg_t;   // {g,f,e,d,c,b,a}, active low
  localparam seg_t SegBlank = 7'h7F;
endpackage

// File: rtl/slot_tick.sv
module slot_tick #(
  parameter int unsigned SLOT_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (SLOT_CYCLES < 2) ? 1 : $clog2(SLOT_CYCLES);
  localparam logic [CW-1:0] LastCnt = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LastCnt) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LastCnt);

  // R5: counter never leaves its range
  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LastCnt);
  // R5: a tick restarts the slot count
  a_r5_tick_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/key_history.sv
module key_history
  import key_disp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  nib_t key_i,
  output nib_t newest_o,
  output nib_t older_o
);
  nib_t newest_q, older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      newest_q <= '0;
      older_q  <= '0;
    end else if (push_i) begin
      newest_q <= key_i;
      older_q  <= newest_q;
    end
  end

  assign newest_o = newest_q;
  assign older_o  = older_q;

  a_r2_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (newest_o == $past(key_i)) && (older_o == $past(newest_o)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(newest_o) && $stable(older_o));
endmodule

// File: rtl/hex_seg_dec.sv
module hex_seg_dec
  import key_disp_pkg::*;
(
  input  nib_t val_i,
  output seg_t seg_no
);
  always_comb begin
    unique case (val_i)
      4'h0: seg_no = 7'h40;
      4'h1: seg_no = 7'h79;
      4'h2: seg_no = 7'h24;
      4'h3: seg_no = 7'h30;
      4'h4: seg_no = 7'h19;
      4'h5: seg_no = 7'h12;
      4'h6: seg_no = 7'h02;
      4'h7: seg_no = 7'h78;
      4'h8: seg_no = 7'h00;
      4'h9: seg_no = 7'h10;
      4'hA: seg_no = 7'h08;
      4'hB: seg_no = 7'h03;
      4'hC: seg_no = 7'h46;
      4'hD: seg_no = 7'h21;
      4'hE: seg_no = 7'h06;
      default: seg_no = 7'h0E;
    endcase
  end
endmodule

// File: rtl/key_hist_disp.sv
module key_hist_disp
  import key_disp_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       new_key_i,
  input  logic [3:0] key_i,
  output logic [6:0] seg_no,
  output logic [1:0] dig_en_no
);
  logic tick;
  logic sel_q;   // 0: newest digit, 1: older digit
  nib_t newest, older, dec_in;
  seg_t dec_out;

  slot_tick #(.SLOT_CYCLES(SLOT_CYCLES)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  key_history u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (new_key_i),
    .key_i   (key_i),
    .newest_o(newest),
    .older_o (older)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= 1'b0;
    else if (tick) sel_q <= ~sel_q;
  end

  assign dec_in = sel_q ? older : newest;

  hex_seg_dec u_dec (
    .val_i (dec_in),
    .seg_no(dec_out)
  );

  assign seg_no    = dec_out;
  assign dig_en_no = sel_q ? 2'b01 : 2'b10;

  a_r4_one_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dig_en_no) == 1);
  a_r5_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (dig_en_no != $past(dig_en_no)));
  a_r5_dwell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(dig_en_no));
  a_r6_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_no != SegBlank);
endmodule

// File: tb/tb_key_hist_disp.sv
`timescale 1ns/1ps
module tb_key_hist_disp;
  localparam int unsigned SLOT = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic new_key_i = 1'b0;
  logic [3:0] key_i = '0;
  logic [6:0] seg_no;
  logic [1:0] dig_en_no;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int n_cyc = 0;
  logic [3:0] m_new = '0, m_old = '0;
  bit last_push = 1'b0;
  bit push_on_switch = 1'b0;

  always #2.5 clk_i = ~clk_i;

  key_hist_disp #(.SLOT_CYCLES(SLOT)) dut (.*);

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: return 7'h40; 4'h1: return 7'h79; 4'h2: return 7'h24; 4'h3: return 7'h30;
      4'h4: return 7'h19; 4'h5: return 7'h12; 4'h6: return 7'h02; 4'h7: return 7'h78;
      4'h8: return 7'h00; 4'h9: return 7'h10; 4'hA: return 7'h08; 4'hB: return 7'h03;
      4'hC: return 7'h46; 4'hD: return 7'h21; 4'hE: return 7'h06; default: return 7'h0E;
    endcase
  endfunction

  function automatic bit exp_sel(input int n);
    return ((n / SLOT) % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, n_cyc);
    end
  endtask

  // Check at negedge, then drive, then advance one edge and update the model.
  task automatic step(input bit push, input logic [3:0] code);
    bit s;
    s = exp_sel(n_cyc);
    chk((s != exp_sel(n_cyc - 1) || n_cyc == 0) ? "R5" : "R4",
        {5'b0, dig_en_no}, {5'b0, s ? 2'b01 : 2'b10});
    if (push_on_switch) chk("R7", seg_no, glyph(s ? m_old : m_new));
    else chk(last_push ? "R2/R6" : "R3/R6", seg_no, glyph(s ? m_old : m_new));
    new_key_i = push;
    key_i = code;
    push_on_switch = push && (exp_sel(n_cyc + 1) != s);
    @(posedge clk_i);
    n_cyc++;
    if (push) begin m_old = m_new; m_new = code; end
    last_push = push;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    new_key_i = 1'b0;
    #1;
    chk("R1", {5'b0, dig_en_no}, 7'h02);
    chk("R1", seg_no, 7'h40);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n_cyc = 0; m_new = '0; m_old = '0; last_push = 1'b0; push_on_switch = 1'b0;
    chk("R1", seg_no, 7'h40);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // idle through several slots: both digits show 0 (R5 timing)
    for (int i = 0; i < 3 * SLOT; i++) step(1'b0, 4'hF);
    // sweep all codes with spacing so each appears on both digits (R6, R2)
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 4'(v));
      for (int j = 0; j < 2 * SLOT; j++) step(1'b0, 4'(v + 3));
    end
    // back-to-back strobes (R2)
    for (int i = 0; i < 5; i++) step(1'b1, 4'(i * 3 + 1));
    // strobe placed on the cycle before a slot switch (R7)
    while (exp_sel(n_cyc + 1) == exp_sel(n_cyc)) step(1'b0, 4'h0);
    step(1'b1, 4'hC);
    for (int i = 0; i < 2 * SLOT; i++) step(1'b0, 4'h0);
    // reset in mid-run (R1)
    do_reset();
    for (int i = 0; i < 2 * SLOT; i++) step(1'b0, 4'h7);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, 4'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule